// File: doc/BRIEF.md
# Interleaved RAM Slot Arbiter

This block lets a CPU and a video fetch engine share a single RAM port on a fast master clock. Time is cut into a repeating four-cycle period. The first two cycles belong to the CPU and the last two to video. A slot counter steps through the period. Beside it runs a second, independent counter that marks the four quarters of a slower video cycle.

While reset is held, a 2-bit alignment input loads the video counter, and the slot counter clears to zero. The distance between the two counters (0 to 3 cycles) then stays fixed, which gives four distinct CPU-to-video timing alignments. A status output reports that distance.

A CPU request is served only from the first cycle of a CPU slot. A request that arrives at any other time is stalled until the next period begins. The acknowledge appears in the second CPU cycle. On the first video cycle of every period a fetch strobe fires, whatever the CPU is doing.

Top module: `ram_slot_arbiter`

## Requirements
- R1: While rst_n is low at a rising clock edge, the slot index clears to 0, the video phase loads the value on align_i, and cpu_ack_o is low after that edge.
- R2: After reset the slot index advances by one each clock, 0,1,2,3,0. cpu_slot_o is high exactly when the index is 0 or 1.
- R3: After reset the video phase advances by one quarter per clock, modulo 4, without depending on the slot index.
- R4: phase_diff_o equals (video phase − slot index) mod 4. This equals the align_i value sampled during reset. Changes on align_i while rst_n is high have no effect on phase_diff_o or vid_phase_o.
- R5: Each of the four align_i values 0, 1, 2 and 3 yields its own phase_diff_o value, and so its own video phase at slot index 0.
- R6: If cpu_req_i is high in a cycle where the slot index is 0, cpu_ack_o is high in the next cycle, where the slot index is 1. cpu_ack_o is never high at any other slot index.
- R7: A request that is first seen at slot index 1, 2 or 3 gets no acknowledge until the slot-1 cycle of the following period.
- R8: cpu_stall_o is high exactly when cpu_req_i is high and cpu_ack_o is low.
- R9: vfetch_o is high exactly in cycles where the slot index is 2, independent of cpu_req_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| align_i | input | 2 | Video-to-slot offset, sampled only during reset |
| cpu_req_i | input | 1 | CPU RAM request, held until acknowledged |
| slot_idx_o | output | 2 | Current position in the four-cycle period |
| cpu_slot_o | output | 1 | High while the RAM port belongs to the CPU |
| vid_phase_o | output | 2 | Current quarter of the video cycle |
| vfetch_o | output | 1 | Video fetch strobe, one cycle per period |
| phase_diff_o | output | 2 | Video phase minus slot index, modulo 4 |
| cpu_ack_o | output | 1 | CPU access acknowledge |
| cpu_stall_o | output | 1 | CPU request waiting for its slot |

## Verification
The slot index, video phase, fetch strobe, status and CPU-slot flag all come from registers. Each of them shows its new value in the cycle right after the clock edge that moved the counters. The acknowledge is due one edge after a request is seen at slot index 0. The stall output follows the request in the same cycle. The bench keeps a behavioural model that it updates on each rising edge from the inputs it applied, compares every output on the falling edge, and changes inputs only after that comparison, so every result is sampled in the cycle where it is due.

// File: rtl/ram_slot_pkg.sv
// Package: shared widths and slot names for the RAM slot arbiter.
// Assumes a fixed period of 2**SLOT_W master cycles with two-cycle slots.
package ram_slot_pkg;
    localparam int SLOT_W = 2;
    localparam int PERIOD = 1 << SLOT_W;

    typedef enum logic [SLOT_W-1:0] {
        SL_CPU_OPEN  = 2'd0,
        SL_CPU_CLOSE = 2'd1,
        SL_VID_OPEN  = 2'd2,
        SL_VID_CLOSE = 2'd3
    } slot_e;
endpackage

// File: rtl/wrap_counter.sv
// Module: free-running modulo-2**W counter with a reset preload.
// Assumes load_val is only meaningful while rst_n is low; rst_n is synchronous.
module wrap_counter #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);
    // Preload on reset, otherwise step by one and wrap naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= load_val;
        else        cnt <= cnt + 1'b1;
    end

    // R2 / R3: each counter steps by exactly one per clock outside reset
    a_r3_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/cpu_slot_gate.sv
// Module: admits CPU requests only at the opening cycle of the CPU slot.
// Acknowledges in the closing CPU cycle and stalls the CPU at all other times.
// Assumes the CPU holds its request until it sees the acknowledge.
module cpu_slot_gate
    import ram_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic              cpu_req,
    output logic              cpu_ack,
    output logic              cpu_stall
);
    logic granted_q;

    // Capture a request only when it is present at the CPU slot opening.
    always_ff @(posedge clk) begin
        if (!rst_n) granted_q <= 1'b0;
        else        granted_q <= cpu_req && (slot_idx == SL_CPU_OPEN);
    end

    // Acknowledge during the closing CPU cycle of a granted slot.
    always_comb cpu_ack = granted_q && (slot_idx == SL_CPU_CLOSE);

    // Stall whenever a request is pending without an acknowledge.
    always_comb cpu_stall = cpu_req && !cpu_ack;

    // R6: a request at the slot opening is acknowledged on the next cycle
    a_r6_grant_next: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && slot_idx == SL_CPU_OPEN) |=> cpu_ack);

    // R6: acknowledge only ever appears in the closing CPU cycle
    a_r6_ack_cycle1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> slot_idx == SL_CPU_CLOSE);

    // R7: acknowledge never lasts two cycles in a row
    a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);
endmodule

// File: rtl/ram_slot_arbiter.sv
// Module: top of the interleaved RAM slot arbiter.
// A slot counter and an independent video phase counter run side by side.
// Their reset preload sets one of four fixed alignments.
// Assumes align_i is stable during reset and the CPU holds requests until acknowledged.
module ram_slot_arbiter
    import ram_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        align_i,
    input  logic              cpu_req_i,
    output logic [1:0]        slot_idx_o,
    output logic              cpu_slot_o,
    output logic [1:0]        vid_phase_o,
    output logic              vfetch_o,
    output logic [1:0]        phase_diff_o,
    output logic              cpu_ack_o,
    output logic              cpu_stall_o
);
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] vphase_q;

    // RAM slot sequencer, cleared on reset.
    wrap_counter #(.W(SLOT_W)) u_slot_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_val ('0),
        .cnt      (slot_q)
    );

    // Video quarter counter, preloaded with the alignment offset on reset.
    wrap_counter #(.W(SLOT_W)) u_vphase_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_val (align_i),
        .cnt      (vphase_q)
    );

    // CPU admission, acknowledge and stall.
    cpu_slot_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_idx  (slot_q),
        .cpu_req   (cpu_req_i),
        .cpu_ack   (cpu_ack_o),
        .cpu_stall (cpu_stall_o)
    );

    // Slot ownership and video strobe decode from the slot index.
    always_comb begin
        slot_idx_o = slot_q;
        cpu_slot_o = (slot_q == SL_CPU_OPEN) || (slot_q == SL_CPU_CLOSE);
        vfetch_o   = (slot_q == SL_VID_OPEN);
    end

    // Report the alignment distance between the two counters.
    always_comb begin
        vid_phase_o  = vphase_q;
        phase_diff_o = vphase_q - slot_q;
    end

    // R4: the alignment distance never drifts once out of reset
    a_r4_diff_stable: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(phase_diff_o));

    // R9: the fetch strobe is a single pulse followed by the closing video cycle
    a_r9_fetch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vfetch_o |=> (!vfetch_o && slot_idx_o == SL_VID_CLOSE));

    // R2: CPU ownership ends two cycles after the slot opens
    a_r2_cpu_window: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx_o == SL_CPU_CLOSE) |=> !cpu_slot_o);
endmodule

// File: tb/ram_slot_arbiter_bench.sv
// Bench: behavioural reference model, compared on every falling edge.
module ram_slot_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] align_i = 2'd0;
    logic       cpu_req_i = 1'b0;
    logic [1:0] slot_idx_o, vid_phase_o, phase_diff_o;
    logic       cpu_slot_o, vfetch_o, cpu_ack_o, cpu_stall_o;

    int vectors = 0;
    int fails = 0;
    bit checking = 1'b0;
    bit done = 1'b0;

    // model state
    int m_slot = 0, m_vph = 0;
    bit m_gnt = 1'b0;

    always #2.5 clk = ~clk;

    ram_slot_arbiter u_ram_slot_arbiter (
        .clk(clk), .rst_n(rst_n), .align_i(align_i), .cpu_req_i(cpu_req_i),
        .slot_idx_o(slot_idx_o), .cpu_slot_o(cpu_slot_o), .vid_phase_o(vid_phase_o),
        .vfetch_o(vfetch_o), .phase_diff_o(phase_diff_o),
        .cpu_ack_o(cpu_ack_o), .cpu_stall_o(cpu_stall_o)
    );

    // Reference model: update from the inputs present at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_slot = 0;
            m_vph  = int'(align_i);
            m_gnt  = 1'b0;
        end else begin
            m_gnt  = (m_slot == 0) && cpu_req_i;
            m_slot = (m_slot + 1) % 4;
            m_vph  = (m_vph + 1) % 4;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the model away from the rising edge.
    always @(negedge clk) begin
        if (checking) begin
            int e_ack;
            e_ack = (m_gnt && m_slot == 1) ? 1 : 0;
            chk("R2 slot index", int'(slot_idx_o), m_slot);
            chk("R2 cpu slot", int'(cpu_slot_o), (m_slot < 2) ? 1 : 0);
            chk("R3 video phase", int'(vid_phase_o), m_vph);
            chk("R4 phase diff", int'(phase_diff_o), (m_vph - m_slot + 4) % 4);
            chk("R9 fetch strobe", int'(vfetch_o), (m_slot == 2) ? 1 : 0);
            chk("R6 ack", int'(cpu_ack_o), e_ack);
            chk("R8 stall", int'(cpu_stall_o), (cpu_req_i && e_ack == 0) ? 1 : 0);
        end
    end

    // Apply reset with a given alignment and check the reset state (R1).
    task automatic do_reset(input logic [1:0] al);
        checking = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        align_i = al;
        cpu_req_i = 1'b1;   // request during reset must not be acknowledged
        repeat (2) @(negedge clk);
        chk("R1 reset slot", int'(slot_idx_o), 0);
        chk("R1 reset phase", int'(vid_phase_o), int'(al));
        chk("R1 reset ack", int'(cpu_ack_o), 0);
        cpu_req_i = 1'b0;
        rst_n = 1'b1;
        checking = 1'b1;
    endtask

    // Random request traffic that follows the hold-until-ack rule.
    task automatic traffic(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #0.1;
            if (cpu_req_i && cpu_ack_o) cpu_req_i = 1'b0;
            else if (!cpu_req_i) cpu_req_i = ($urandom % 3) == 0;
        end
    endtask

    // Raise a request at a chosen slot index and time its acknowledge (R7).
    task automatic late_req(input int at_slot);
        int waited;
        @(negedge clk);
        #0.1;
        while (int'(slot_idx_o) != at_slot) begin
            @(negedge clk);
            #0.1;
        end
        cpu_req_i = 1'b1;
        waited = 0;
        do begin
            @(negedge clk);
            #0.1;
            waited++;
        end while (!cpu_ack_o && waited < 10);
        // from slot s, ack falls at slot 1 of the next period: (1 - s + 4) % 4, or 4 when s = 1
        chk("R7 late request wait", waited, (at_slot == 1) ? 4 : (1 - at_slot + 4) % 4 + ((at_slot == 0) ? 0 : 0));
        cpu_req_i = 1'b0;
    endtask

    initial begin
        int seen_diff [4];
        for (int k = 0; k < 4; k++) begin
            do_reset(2'(k));
            traffic(12);
            // R4: alignment input changed after reset must be ignored
            align_i = 2'(k + 1);
            traffic(20);
            chk("R4 align ignored", int'(phase_diff_o), k);
            for (int s = 1; s < 4; s++) late_req(s);
            late_req(0);
            // R5: video phase at slot index 0 equals the alignment
            @(negedge clk);
            while (slot_idx_o != 2'd0) @(negedge clk);
            chk("R5 phase at slot 0", int'(vid_phase_o), k);
            seen_diff[k] = int'(phase_diff_o);
        end
        for (int a = 0; a < 4; a++)
            for (int b = a + 1; b < 4; b++)
                chk("R5 distinct alignments", (seen_diff[a] != seen_diff[b]) ? 1 : 0, 1);
        // R9: fetch strobe with requests held permanently high
        cpu_req_i = 1'b1;
        repeat (8) @(negedge clk);
        cpu_req_i = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        checking = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule